// File: doc/BRIEF.md
# Counter-Mode Block Stepper

This unit holds the 128-bit counter block that a counter-mode cipher core encrypts to make its keystream. After each processed block the host (or sequencer) pulses an advance strobe and the unit increments only a low-order field of the block. The bits above that field stay fixed, and a carry out of the field is dropped, so the field wraps to zero on its own.

The width of the incrementing field comes from a 2-bit width select (32, 64, 128 or 192 bits). Two mode selects override it. The integer-counter mode forces a 16-bit field. The Galois/counter authenticated mode forces a 32-bit field, and the Galois/counter mode wins if both selects are high. A load port writes the initial vector, and a load takes priority over an advance in the same cycle. While the Galois/counter select is high the unit counts advances since the last load. It raises a sticky limit flag when an advance would carry the job past its legal block count, which is 2^32 − 2 blocks with the default counter width.

Top module: `ctr_block_stepper`

## Requirements
- R1: After reset `ctr_block` is all zeros and `gcm_limit_err` is low.
- R2: With both mode selects low, `width_sel` picks the field width: 0 = low 32 bits, 1 = low 64 bits, 2 = all 128 bits. An advance adds one to that field, and the new value appears on `ctr_block` one clock later.
- R3: A carry out of the selected field never reaches the bits above it: an all-ones field wraps to zero and the upper bits keep their value.
- R4: With `width_sel` = 3 (192-bit setting) the whole 128-bit block increments, and all ones wraps to all zeros.
- R5: With `icm_sel` high and `gcm_sel` low, the field is the low 16 bits, whatever `width_sel` says.
- R6: With `gcm_sel` high, the field is the low 32 bits, whatever `width_sel` and `icm_sel` say.
- R7: With `load_en` high, `ctr_block` takes `load_block` at the next clock, even when `step_en` is high in the same cycle.
- R8: With `load_en` and `step_en` both low, `ctr_block` does not change.
- R9: Advances taken while `gcm_sel` is high are counted from the last load. With LIMIT = 2^CNT_W − 2, the first LIMIT such advances leave `gcm_limit_err` low. The next one sets it one clock later, and it then stays high until a load.
- R10: A load clears the block count and `gcm_limit_err`, including when an over-limit advance falls in the same cycle.
- R11: Advances taken while `gcm_sel` is low neither add to the block count nor set `gcm_limit_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| load_en | input | 1 | Load the initial vector from `load_block` |
| load_block | input | BLK_W | Initial counter block |
| step_en | input | 1 | Advance strobe, one per processed block |
| width_sel | input | 2 | Field width: 0=32, 1=64, 2=128, 3=192 (whole block) |
| icm_sel | input | 1 | Integer-counter mode, forces a 16-bit field |
| gcm_sel | input | 1 | Galois/counter mode, forces a 32-bit field and enables the block count |
| ctr_block | output | BLK_W | Current counter block to the cipher core |
| gcm_limit_err | output | 1 | Sticky flag: the block count passed its legal limit |

## Verification
Two functions can fall in the same cycle: a load of a new initial vector, and an advance. The bench drives both strobes on one edge, once with an ordinary block and once when the Galois/counter block count is already at its limit. It then expects the loaded value unchanged and the limit flag low, which shows that the load wins and that the advance neither increments the block nor is counted. With the bench's small counter width the limit boundary is walked block by block, and the flag is expected low on the last legal advance and high from the next one onward.

// File: rtl/ctr_stepper_pkg.sv
package ctr_stepper_pkg;

  typedef enum logic [1:0] {
    CW_32  = 2'd0,
    CW_64  = 2'd1,
    CW_128 = 2'd2,
    CW_192 = 2'd3
  } ctr_width_e;

  localparam int ICM_FIELD_BITS = 16;
  localparam int GCM_FIELD_BITS = 32;

  // Width of the incrementing field in bits; mode selects override width_sel.
  function automatic int field_bits(input ctr_width_e wsel, input logic icm, input logic gcm);
    int bits;
    if (gcm)      bits = GCM_FIELD_BITS;
    else if (icm) bits = ICM_FIELD_BITS;
    else begin
      case (wsel)
        CW_32:   bits = 32;
        CW_64:   bits = 64;
        CW_128:  bits = 128;
        default: bits = 192;
      endcase
    end
    return bits;
  endfunction

endpackage

// File: rtl/ctr_field_select.sv
module ctr_field_select
  import ctr_stepper_pkg::*;
#(
  parameter int BLK_W = 128
) (
  input  logic [1:0]       width_sel,
  input  logic             icm_sel,
  input  logic             gcm_sel,
  output logic [BLK_W-1:0] field_mask
);

  int sel_bits;

  always_comb begin
    sel_bits = field_bits(ctr_width_e'(width_sel), icm_sel, gcm_sel);
    for (int i = 0; i < BLK_W; i++) begin
      field_mask[i] = (i < sel_bits);
    end
  end

  // R5/R6: the mode selects override the width select
  always_comb begin
    if (gcm_sel)
      a_r6_gcm_field: assert (field_mask[31] && !field_mask[32]);
    else if (icm_sel)
      a_r5_icm_field: assert (field_mask[15] && !field_mask[16]);
  end

endmodule

// File: rtl/ctr_field_adder.sv
module ctr_field_adder #(
  parameter int BLK_W = 128
) (
  input  logic [BLK_W-1:0] cur_blk,
  input  logic [BLK_W-1:0] field_mask,
  output logic [BLK_W-1:0] next_blk
);

  // Increment inside the mask; the carry beyond it is discarded.
  function automatic logic [BLK_W-1:0] masked_inc(input logic [BLK_W-1:0] blk,
                                                  input logic [BLK_W-1:0] msk);
    logic [BLK_W-1:0] bumped;
    bumped = blk + {{(BLK_W-1){1'b0}}, 1'b1};
    return (bumped & msk) | (blk & ~msk);
  endfunction

  assign next_blk = masked_inc(cur_blk, field_mask);

  // R3: upper bits never see the field carry
  always_comb begin
    a_r3_upper_kept: assert ((next_blk ^ cur_blk) == ((next_blk ^ cur_blk) & field_mask));
  end

endmodule

// File: rtl/gcm_block_guard.sv
module gcm_block_guard #(
  parameter int CNT_W = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_en,
  input  logic step_en,
  input  logic gcm_sel,
  output logic limit_err
);

  localparam logic [CNT_W-1:0] LIMIT = {{(CNT_W-1){1'b1}}, 1'b0};

  logic [CNT_W-1:0] blk_cnt;
  logic             gcm_step;
  logic             over_limit;

  assign gcm_step   = step_en & gcm_sel & ~load_en;
  assign over_limit = gcm_step & (blk_cnt == LIMIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blk_cnt   <= '0;
      limit_err <= 1'b0;
    end else if (load_en) begin
      blk_cnt   <= '0;
      limit_err <= 1'b0;
    end else begin
      if (gcm_step && blk_cnt != LIMIT) blk_cnt <= blk_cnt + 1'b1;
      if (over_limit) limit_err <= 1'b1;
    end
  end

  a_r9_cnt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    blk_cnt <= LIMIT);
  a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    limit_err && !load_en |=> limit_err);
  a_r10_load_clears: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> !limit_err && blk_cnt == '0);
  a_r11_no_count_off: assert property (@(posedge clk) disable iff (!rst_n)
    !gcm_sel && !load_en |=> $stable(blk_cnt) && limit_err == $past(limit_err));

endmodule

// File: rtl/ctr_block_stepper.sv
module ctr_block_stepper #(
  parameter int BLK_W = 128,
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_en,
  input  logic [BLK_W-1:0] load_block,
  input  logic             step_en,
  input  logic [1:0]       width_sel,
  input  logic             icm_sel,
  input  logic             gcm_sel,
  output logic [BLK_W-1:0] ctr_block,
  output logic             gcm_limit_err
);

  logic [BLK_W-1:0] field_mask;
  logic [BLK_W-1:0] stepped_blk;
  logic [BLK_W-1:0] blk_q;
  logic             take_step;

  assign take_step = step_en & ~load_en;

  ctr_field_select #(.BLK_W(BLK_W)) u_sel (
    .width_sel  (width_sel),
    .icm_sel    (icm_sel),
    .gcm_sel    (gcm_sel),
    .field_mask (field_mask)
  );

  ctr_field_adder #(.BLK_W(BLK_W)) u_add (
    .cur_blk    (blk_q),
    .field_mask (field_mask),
    .next_blk   (stepped_blk)
  );

  gcm_block_guard #(.CNT_W(CNT_W)) u_guard (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_en   (load_en),
    .step_en   (step_en),
    .gcm_sel   (gcm_sel),
    .limit_err (gcm_limit_err)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         blk_q <= '0;
    else if (load_en)   blk_q <= load_block;
    else if (take_step) blk_q <= stepped_blk;
  end

  assign ctr_block = blk_q;

  a_r7_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> ctr_block == $past(load_block));
  a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !load_en && !step_en |=> $stable(ctr_block));
  a_r2_w32_upper: assert property (@(posedge clk) disable iff (!rst_n)
    take_step && !gcm_sel && !icm_sel && width_sel == 2'd0
      |=> ctr_block[BLK_W-1:32] == $past(ctr_block[BLK_W-1:32]));
  a_r5_icm_upper: assert property (@(posedge clk) disable iff (!rst_n)
    take_step && !gcm_sel && icm_sel |=> ctr_block[BLK_W-1:16] == $past(ctr_block[BLK_W-1:16]));
  a_r6_gcm_upper: assert property (@(posedge clk) disable iff (!rst_n)
    take_step && gcm_sel |=> ctr_block[BLK_W-1:32] == $past(ctr_block[BLK_W-1:32]));

endmodule

// File: tb/test_ctr_block_stepper.sv
module test_ctr_block_stepper;

  localparam int BW = 128;
  localparam int CW = 3;
  localparam int LIM = (1 << CW) - 2;

  typedef struct {
    logic [BW-1:0] blk;
    logic          err;
    string         tag;
  } exp_t;

  logic          clk = 0;
  logic          rst_n = 0;
  logic          load_en = 0;
  logic [BW-1:0] load_block = '0;
  logic          step_en = 0;
  logic [1:0]    width_sel = 0;
  logic          icm_sel = 0;
  logic          gcm_sel = 0;
  logic [BW-1:0] ctr_block;
  logic          gcm_limit_err;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  exp_t sb[$];

  logic [BW-1:0] m_blk = '0;
  int            m_cnt = 0;
  logic          m_err = 0;

  always #5 clk = ~clk;

  ctr_block_stepper #(.BLK_W(BW), .CNT_W(CW)) i_ctr_block_stepper (
    .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_block(load_block),
    .step_en(step_en), .width_sel(width_sel), .icm_sel(icm_sel), .gcm_sel(gcm_sel),
    .ctr_block(ctr_block), .gcm_limit_err(gcm_limit_err)
  );

  // Independent model: field of n bits counts modulo 2^n, rest untouched.
  function automatic logic [BW-1:0] model_step(logic [BW-1:0] b, int n);
    logic [BW-1:0] lo, hi;
    if (n >= BW) return b + 1;
    lo = b << (BW - n) >> (BW - n);
    hi = b >> n << n;
    lo = (lo + 1) << (BW - n) >> (BW - n);
    return hi | lo;
  endfunction

  task automatic drive(bit ld, logic [BW-1:0] v, bit st, logic [1:0] ws, bit icm, bit gcm, string tag);
    int n;
    exp_t e;
    @(negedge clk);
    load_en = ld; load_block = v; step_en = st; width_sel = ws; icm_sel = icm; gcm_sel = gcm;
    n = gcm ? 32 : icm ? 16 : (ws == 0) ? 32 : (ws == 1) ? 64 : (ws == 2) ? 128 : 192;
    if (ld) begin
      m_blk = v; m_cnt = 0; m_err = 0;
    end else if (st) begin
      m_blk = model_step(m_blk, n);
      if (gcm) begin
        if (m_cnt == LIM) m_err = 1;
        else m_cnt++;
      end
    end
    e.blk = m_blk; e.err = m_err; e.tag = tag;
    sb.push_back(e);
  endtask

  always @(posedge clk) begin
    #2;
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      total++;
      if (ctr_block !== e.blk || gcm_limit_err !== e.err) begin
        bad++;
        $display("FAIL %s: blk=%h err=%b expected blk=%h err=%b", e.tag, ctr_block, gcm_limit_err, e.blk, e.err);
      end
    end
  end

  initial begin
    #100000;
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    total++;
    if (ctr_block !== '0 || gcm_limit_err !== 1'b0) begin
      bad++;
      $display("FAIL R1: blk=%h err=%b expected blk=0 err=0", ctr_block, gcm_limit_err);
    end
    rst_n = 1;

    // R2/R3 32-bit field wraps, upper held
    drive(1, {96'hA5A5_0000_1111_2222_3333_4444, 32'hFFFF_FFFE}, 0, 0, 0, 0, "R7 load");
    drive(0, '0, 1, 0, 0, 0, "R2 w32 step");
    drive(0, '0, 1, 0, 0, 0, "R3 w32 wrap");
    drive(0, '0, 0, 0, 0, 0, "R8 idle");
    drive(0, '0, 1, 0, 0, 0, "R2 w32 after wrap");
    // R2/R3 64-bit
    drive(1, {64'h0123_4567_89AB_CDEF, 64'hFFFF_FFFF_FFFF_FFFF}, 0, 1, 0, 0, "R7 load64");
    drive(0, '0, 1, 1, 0, 0, "R3 w64 wrap");
    drive(0, '0, 1, 1, 0, 0, "R2 w64 step");
    // R2 128-bit carries across bit 64
    drive(1, {64'h0, 64'hFFFF_FFFF_FFFF_FFFF}, 0, 2, 0, 0, "R7 load128");
    drive(0, '0, 1, 2, 0, 0, "R2 w128 carry");
    // R4 192 setting wraps whole block
    drive(1, {BW{1'b1}}, 0, 3, 0, 0, "R7 loadones");
    drive(0, '0, 1, 3, 0, 0, "R4 w192 wrap");
    drive(0, '0, 1, 3, 0, 0, "R4 w192 step");
    // R5 ICM overrides width_sel
    drive(1, {112'h1234, 16'hFFFF}, 0, 2, 1, 0, "R7 loadicm");
    drive(0, '0, 1, 2, 1, 0, "R5 icm wrap");
    drive(0, '0, 1, 3, 1, 0, "R5 icm step");
    // R7 load and step same cycle
    drive(1, {BW{1'b0}} | 128'hDEAD, 1, 0, 0, 0, "R7 load+step");
    drive(0, '0, 0, 0, 0, 0, "R8 idle after load");
    // R11 non-GCM steps not counted
    for (int k = 0; k < LIM + 2; k++) drive(0, '0, 1, 0, 0, 0, "R11 non-gcm");
    // R6/R9 GCM count up to limit
    drive(1, {96'h77, 32'hFFFF_FFFD}, 0, 2, 1, 0, "R10 load gcm");
    for (int k = 0; k < LIM; k++) drive(0, '0, 1, 2, 1, 1, "R6 R9 gcm legal");
    drive(0, '0, 1, 1, 0, 1, "R9 gcm over");
    drive(0, '0, 0, 0, 0, 1, "R9 sticky");
    drive(0, '0, 1, 0, 0, 0, "R9 sticky non-gcm");
    drive(1, 128'h5, 0, 0, 0, 1, "R10 load clears");
    // R10 load with over-limit step same cycle
    for (int k = 0; k < LIM; k++) drive(0, '0, 1, 0, 0, 1, "R9 refill");
    drive(1, 128'h9, 1, 0, 0, 1, "R10 load+overstep");
    drive(0, '0, 1, 0, 0, 1, "R10 count restarted");
    drive(0, '0, 0, 0, 0, 0, "end");
    repeat (3) @(negedge clk);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule